// File: doc/BRIEF.md
# Converter Conversion Timing Sequencer

This block times the control phases of a successive-approximation analog converter that sits outside it. A start request begins a single conversion, or the first of a chain when continuous mode is held on. The sequencer counts converter-clock ticks through a sample phase and a convert phase. A single or first conversion then runs a short tail of bus cycles before it raises a one-cycle strobe that loads the result registers. The whole block runs on the bus clock. The converter clock is a one-cycle enable: one of four sources is picked and then divided by 1, 2, 4 or 8.

Total length depends on four things: resolution, short or long sampling, whether the conversion is single/first or a later one in a chain, and whether the slow asynchronous source is in use. A wake-up delay is counted in bus cycles before the first conversion on that source. A new start request at any point aborts the running conversion and begins again as a first conversion.

Top module: `adc_conv_timer`

## Requirements
- R1: With `res_mode` 01 (12-bit), 10 or 11 (10-bit), a single or first conversion counts 23 converter ticks with `long_smp`=0 or 43 with `long_smp`=1. It then waits `TAIL_CYC` (default 5) bus cycles before `latch_stb`. On the bus source at divide-by-1, `latch_stb` is high after the 28th (or 48th) rising edge counted from the edge that samples `start`.
- R2: With `res_mode` 00 (8-bit), a single or first conversion counts 20 converter ticks (short) or 40 (long), followed by the same bus-cycle tail.
- R3: If `cont_en` is high when a conversion completes, the next conversion begins on that same edge. It has no wake-up, no tail, and latches on its last tick after 20/40 ticks (10/12-bit) or 17/37 ticks (8-bit). If `cont_en` is low when a conversion completes, the block goes idle and produces no further strobes.
- R4: With `clk_sel` 11, a single or first conversion waits `WAKE_CYC` bus cycles before it counts any tick, and no phase strobe is high during the wait. Later conversions in a chain do not wait.
- R5: `clk_sel` chooses the tick source: 00 is every bus cycle, 01 is every second bus cycle, 10 is `alt_tick`, and 11 is `async_tick`. `clk_div` 00/01/10/11 divides the source by 1/2/4/8. The divider phase restarts with each conversion, so one converter tick takes exactly source-period × ratio bus cycles. While the source gives no ticks, no progress is made.
- R6: `sample_phase` is high for 7 or 27 ticks on a single/first conversion, or 4 or 24 ticks on a later one (short/long sampling). `convert_phase` is then high for 16 ticks (10/12-bit) or 13 ticks (8-bit). The two are never high together.
- R7: `start` during a conversion aborts it and times a fresh first conversion from that edge. `done` and `latch_stb` are low in the following cycle.
- R8: `latch_stb` is a one-cycle pulse per completed conversion. `done` rises with it and stays high until the next `start`.
- R9: Resolution, sample length, clock select and divide are captured at `start`. Changes to them during a conversion or a chain have no effect on its timing.
- R10: After reset, `sample_phase`, `convert_phase`, `latch_stb` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start or restart request, one bus cycle |
| res_mode | input | 2 | 00 8-bit, 01 12-bit, 10/11 10-bit |
| long_smp | input | 1 | 1 selects long sampling |
| cont_en | input | 1 | Continuous chaining enable, checked at each completion |
| clk_sel | input | 2 | Converter tick source select |
| clk_div | input | 2 | Divide ratio 1, 2, 4, 8 |
| alt_tick | input | 1 | Alternate synchronous source enable |
| async_tick | input | 1 | Asynchronous source enable, already synchronised |
| sample_phase | output | 1 | High during the sample phase |
| convert_phase | output | 1 | High during the convert phase |
| latch_stb | output | 1 | One-cycle result-register load strobe |
| done | output | 1 | Conversion complete flag |

## Verification
The bench builds the block with `WAKE_CYC` = 6 and the default tail of 5. The short wake-up lets wake-up chains, aborts and sync-source runs all share one short run while keeping the wait clearly visible in the measured totals. With the bus, half-rate and always-on external sources, every total and interval is an exact bus-cycle count. The bench can therefore check each resolution, sampling and divide combination, plus the first-versus-later difference, to the cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Converter-tick budget of the conversion algorithm
  localparam int OVH_TICKS  = 3;   // extra sample setup on single/first
  localparam int SMP_SHORT  = 4;
  localparam int SMP_LONG   = 24;
  localparam int CNV_WIDE   = 16;  // 10/12-bit
  localparam int CNV_NARROW = 13;  // 8-bit
  localparam int TICK_W     = $clog2(OVH_TICKS + SMP_LONG + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SAMPLE,
    ST_CONVERT,
    ST_TAIL
  } seq_state_e;

  typedef struct packed {
    logic       res8;
    logic       long_smp;
    logic [1:0] sel;
    logic [1:0] div;
  } conv_cfg_t;

  function automatic logic [TICK_W-1:0] sample_ticks(input logic first, input logic lng);
    int t;
    t = lng ? SMP_LONG : SMP_SHORT;
    if (first) t = t + OVH_TICKS;
    return TICK_W'(t);
  endfunction

  function automatic logic [TICK_W-1:0] convert_ticks(input logic res8);
    return res8 ? TICK_W'(CNV_NARROW) : TICK_W'(CNV_WIDE);
  endfunction

  function automatic logic [2:0] div_limit(input logic [1:0] d);
    case (d)
      2'b00:   return 3'd0;
      2'b01:   return 3'd1;
      2'b10:   return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] sel,
  input  logic [1:0] div,
  input  logic       alt_tick,
  input  logic       async_tick,
  output logic       adck_tick
);

  logic       half_q;
  logic [2:0] div_cnt;
  logic [2:0] lim;
  logic       src_tick;

  always_comb begin
    case (sel)
      2'b00:   src_tick = 1'b1;
      2'b01:   src_tick = half_q;
      2'b10:   src_tick = alt_tick;
      default: src_tick = async_tick;
    endcase
  end

  assign lim       = div_limit(div);
  assign adck_tick = src_tick && (div_cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      div_cnt <= '0;
    end else if (restart) begin
      half_q  <= 1'b0;
      div_cnt <= '0;
    end else begin
      half_q <= ~half_q;
      if (src_tick) div_cnt <= (div_cnt == lim) ? 3'd0 : div_cnt + 3'd1;
    end
  end

  assert_div_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= lim);

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (div_cnt == 3'd0) && !half_q);

endmodule

// File: rtl/adc_wake_timer.sv
module adc_wake_timer #(
  parameter int WAKE_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic arm_async,
  output logic wake_done
);

  localparam int W = $clog2(WAKE_CYC + 1);

  logic [W-1:0] cnt;

  assign wake_done = (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (arm)        cnt <= arm_async ? W'(WAKE_CYC) : '0;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assert_wake_counts_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && cnt != '0) |=> (cnt == W'($past(cnt) - W'(1))));

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int WAKE_CYC = 40,
  parameter int TAIL_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] res_mode,
  input  logic       long_smp,
  input  logic       cont_en,
  input  logic [1:0] clk_sel,
  input  logic [1:0] clk_div,
  input  logic       alt_tick,
  input  logic       async_tick,
  output logic       sample_phase,
  output logic       convert_phase,
  output logic       latch_stb,
  output logic       done
);

  localparam int TAIL_W = $clog2(TAIL_CYC + 1);

  seq_state_e        state;
  conv_cfg_t         cfg_q;
  logic              first_q;
  logic [TICK_W-1:0] tick_cnt;
  logic [TAIL_W-1:0] tail_cnt;

  // Named internal events
  logic              adck_tick;
  logic              wake_done;
  logic [TICK_W-1:0] smp_target;
  logic [TICK_W-1:0] cnv_target;
  logic              smp_last;
  logic              cnv_last;
  logic              tail_last;
  logic              conv_finish;
  logic              chain_next;
  logic              gen_restart;

  assign smp_target  = sample_ticks(first_q, cfg_q.long_smp);
  assign cnv_target  = convert_ticks(cfg_q.res8);
  assign smp_last    = (state == ST_SAMPLE) && adck_tick && (tick_cnt == smp_target - TICK_W'(1));
  assign cnv_last    = (state == ST_CONVERT) && adck_tick && (tick_cnt == cnv_target - TICK_W'(1));
  assign tail_last   = (state == ST_TAIL) && (tail_cnt == TAIL_W'(TAIL_CYC - 1));
  assign conv_finish = (cnv_last && !first_q) || tail_last;
  assign chain_next  = conv_finish && cont_en;
  assign gen_restart = start || ((state == ST_WAKE) && wake_done) || chain_next;

  assign sample_phase  = (state == ST_SAMPLE);
  assign convert_phase = (state == ST_CONVERT);

  adc_clk_gen u_clk_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (gen_restart),
    .sel        (cfg_q.sel),
    .div        (cfg_q.div),
    .alt_tick   (alt_tick),
    .async_tick (async_tick),
    .adck_tick  (adck_tick)
  );

  adc_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (start),
    .arm_async (clk_sel == 2'b11),
    .wake_done (wake_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cfg_q     <= '0;
      first_q   <= 1'b1;
      tick_cnt  <= '0;
      tail_cnt  <= '0;
      latch_stb <= 1'b0;
      done      <= 1'b0;
    end else if (start) begin
      state          <= (clk_sel == 2'b11) ? ST_WAKE : ST_SAMPLE;
      cfg_q.res8     <= (res_mode == 2'b00);
      cfg_q.long_smp <= long_smp;
      cfg_q.sel      <= clk_sel;
      cfg_q.div      <= clk_div;
      first_q        <= 1'b1;
      tick_cnt       <= '0;
      tail_cnt       <= '0;
      latch_stb      <= 1'b0;
      done           <= 1'b0;
    end else begin
      latch_stb <= 1'b0;
      case (state)
        ST_WAKE:
          if (wake_done) state <= ST_SAMPLE;
        ST_SAMPLE:
          if (adck_tick) begin
            if (smp_last) begin
              state    <= ST_CONVERT;
              tick_cnt <= '0;
            end else begin
              tick_cnt <= tick_cnt + TICK_W'(1);
            end
          end
        ST_CONVERT:
          if (adck_tick) begin
            if (cnv_last) begin
              tick_cnt <= '0;
              if (first_q) begin
                state    <= ST_TAIL;
                tail_cnt <= '0;
              end
            end else begin
              tick_cnt <= tick_cnt + TICK_W'(1);
            end
          end
        ST_TAIL:
          tail_cnt <= tail_cnt + TAIL_W'(1);
        default: ;
      endcase
      if (conv_finish) begin
        latch_stb <= 1'b1;
        done      <= 1'b1;
        first_q   <= 1'b0;
        tick_cnt  <= '0;
        state     <= cont_en ? ST_SAMPLE : ST_IDLE;
      end
    end
  end

  assert_phase_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_phase && convert_phase));

  assert_sample_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SAMPLE) |-> (tick_cnt < smp_target));

  assert_wake_async_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE) |-> (cfg_q.sel == 2'b11) && first_q);

  assert_tail_first_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL) |-> first_q);

  assert_chain_resumes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_next && !start) |=> sample_phase && !first_q);

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !latch_stb);

  assert_latch_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> !latch_stb);

  assert_done_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> latch_stb);

endmodule

// File: tb/adc_conv_timer_bench.sv
module adc_conv_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WAKE = 6;
  localparam int TAIL = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] res_mode = 2'b10;
  logic       long_smp = 1'b0;
  logic       cont_en = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic [1:0] clk_div = 2'b00;
  logic       alt_tick = 1'b1;
  logic       async_tick = 1'b1;
  logic       sample_phase, convert_phase, latch_stb, done;

  int n_checks = 0;
  int n_fail = 0;
  int last_smp, last_cnv;
  bit last_done_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_conv_timer #(.WAKE_CYC(WAKE), .TAIL_CYC(TAIL)) u_adc_conv_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .res_mode(res_mode),
    .long_smp(long_smp), .cont_en(cont_en), .clk_sel(clk_sel), .clk_div(clk_div),
    .alt_tick(alt_tick), .async_tick(async_tick), .sample_phase(sample_phase),
    .convert_phase(convert_phase), .latch_stb(latch_stb), .done(done)
  );

  function automatic int tick_total(input int res, input bit lng, input bit first);
    int t;
    if (res == 0) t = lng ? 40 : 20;
    else          t = lng ? 43 : 23;
    if (!first) t = t - 3;
    return t;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int res, input bit lng, input int sel, input int dv, input bit cont);
    @(negedge clk);
    res_mode = 2'(res); long_smp = lng; clk_sel = 2'(sel); clk_div = 2'(dv); cont_en = cont;
  endtask

  // Pulse start, count rising edges from the sampling edge to the first latch
  task automatic run_first(input bit meddle, output int cyc);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    last_done_clr = !done;
    last_smp = int'(sample_phase);
    last_cnv = int'(convert_phase);
    if (meddle) begin
      long_smp = ~long_smp; res_mode = 2'b00; clk_div = 2'b11; clk_sel = 2'b01;
    end
    while (!latch_stb && cyc < 3000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (!latch_stb) begin
        last_smp += int'(sample_phase);
        last_cnv += int'(convert_phase);
      end
    end
  endtask

  task automatic next_latch(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end while (!latch_stb && cyc < 3000);
  endtask

  task automatic settle_idle();
    cont_en = 1'b0;
    repeat (400) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10", "sample_phase after reset", int'(sample_phase), 0);
    chk("R10", "convert_phase after reset", int'(convert_phase), 0);
    chk("R10", "latch_stb after reset", int'(latch_stb), 0);
    chk("R10", "done after reset", int'(done), 0);
  endtask

  task automatic t_single();
    int c;
    for (int r = 0; r < 4; r++) begin
      for (int l = 0; l < 2; l++) begin
        set_cfg(r, l[0], 0, 0, 0);
        run_first(0, c);
        chk((r == 0) ? "R2" : "R1", $sformatf("single res%0d long%0d", r, l), c, tick_total(r, l[0], 1) + TAIL);
        @(negedge clk);
        chk("R8", "latch is one cycle", int'(latch_stb), 0);
        chk("R8", "done after single", int'(done), 1);
      end
    end
  endtask

  task automatic t_divide();
    int c;
    for (int d = 1; d < 4; d++) begin
      set_cfg(2, 0, 0, d, 0);
      run_first(0, c);
      chk("R5", $sformatf("bus div code %0d 10-bit short", d), c, (1 << d) * 23 + TAIL);
      set_cfg(0, 1, 0, d, 0);
      run_first(0, c);
      chk("R5", $sformatf("bus div code %0d 8-bit long", d), c, (1 << d) * 40 + TAIL);
    end
    for (int d = 0; d < 2; d++) begin
      set_cfg(1, 0, 1, d, 0);
      run_first(0, c);
      chk("R5", $sformatf("half-rate source div code %0d", d), c, 2 * (1 << d) * 23 + TAIL);
    end
  endtask

  task automatic t_alt_src();
    int c;
    set_cfg(2, 0, 2, 0, 0);
    alt_tick = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (50) @(negedge clk);
    chk("R5", "no progress without alt ticks (sampling)", int'(sample_phase), 1);
    chk("R5", "no latch without alt ticks", int'(done), 0);
    alt_tick = 1'b1;
    next_latch(c);
    chk("R5", "alt source remaining length", c, 23 + TAIL);
  endtask

  task automatic t_async();
    int c;
    set_cfg(2, 0, 3, 0, 0);
    run_first(0, c);
    chk("R4", "async single includes wake-up", c, WAKE + 23 + TAIL);
    chk("R4", "no sampling during wake-up", last_smp, 7);
    set_cfg(0, 1, 3, 0, 1);
    run_first(0, c);
    chk("R4", "async first in chain", c, WAKE + 40 + TAIL);
    next_latch(c);
    chk("R4", "async later conversion skips wake-up", c, 37);
    settle_idle();
  endtask

  task automatic t_phases();
    int c;
    set_cfg(2, 0, 0, 0, 0);
    run_first(0, c);
    chk("R6", "sample ticks 10-bit short first", last_smp, 7);
    chk("R6", "convert ticks 10-bit", last_cnv, 16);
    set_cfg(0, 1, 0, 0, 0);
    run_first(0, c);
    chk("R6", "sample ticks long first", last_smp, 27);
    chk("R6", "convert ticks 8-bit", last_cnv, 13);
  endtask

  task automatic t_cont();
    int c;
    int s;
    for (int r = 0; r < 3; r += 2) begin
      for (int l = 0; l < 2; l++) begin
        set_cfg(r, l[0], 0, 0, 1);
        run_first(0, c);
        chk("R3", $sformatf("chain first res%0d long%0d", r, l), c, tick_total(r, l[0], 1) + TAIL);
        next_latch(c);
        chk("R3", $sformatf("chain later res%0d long%0d", r, l), c, tick_total(r, l[0], 0));
        cont_en = 1'b0;
        next_latch(c);
        chk("R3", "final conversion before stop", c, tick_total(r, l[0], 0));
        s = 0;
        repeat (80) begin
          @(negedge clk);
          s += int'(latch_stb) + int'(sample_phase) + int'(convert_phase);
        end
        chk("R3", "idle after chain stops", s, 0);
      end
    end
    set_cfg(2, 0, 0, 1, 1);
    run_first(0, c);
    next_latch(c);
    chk("R3", "later conversion at divide 2", c, 2 * 20);
    settle_idle();
  endtask

  task automatic t_abort();
    int c;
    set_cfg(2, 0, 0, 0, 0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    run_first(0, c);
    chk("R7", "restart times a fresh first conversion", c, 23 + TAIL);
    chk("R7", "done cleared by restart", int'(last_done_clr), 1);
  endtask

  task automatic t_done_hold();
    int c;
    set_cfg(0, 0, 0, 0, 0);
    run_first(0, c);
    repeat (20) @(negedge clk);
    chk("R8", "done held while idle", int'(done), 1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R8", "done cleared by start", int'(done), 0);
    next_latch(c);
  endtask

  task automatic t_cfg_lock();
    int c;
    set_cfg(2, 0, 0, 0, 0);
    run_first(1, c);
    chk("R9", "mid-conversion config change ignored", c, 23 + TAIL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_divide();
    t_alt_src();
    t_async();
    t_phases();
    t_cont();
    t_abort();
    t_done_hold();
    t_cfg_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule